// File: doc/BRIEF.md
# Programmable Linear-FM Chirp Burst Generator

The block drives the digital front of a radar transmitter. It produces a burst of linear-FM pulses as a stream of phase words, one word per sample clock. A separate sine table and DAC, outside this block, turn the words into a waveform. Six settings fully describe the burst: the lower and upper limits of the frequency word, the per-sample slope, the gate length, the repetition period and the pulse count. Software writes them through a small write port.

Writes go to a shadow bank. A start command copies the bank into a working set, so settings can be changed between bursts without touching anything else.

During a burst the frequency word climbs by the slope on every sample and is clamped at the upper limit. The phase accumulator integrates the frequency word. Both restart at every pulse boundary, so each pulse has the same starting phase. A one-cycle completion strobe marks the end of the burst. A start with an inconsistent timing setup is refused with a one-cycle error strobe.

Top module: `lfm_chirp_gen`

## Requirements
- R1: While reset is asserted and after its release, with no start given, `tx_gate_o`, `done_o` and `err_o` are 0 and `phase_o` is 0.
- R2: A start accepted at a clock edge begins the burst in the next cycle. Within each repetition period of `period` cycles, `tx_gate_o` is high for the first `on_len` cycles. Periods follow one another with no gap.
- R3: Sample k of a pulse (k = 0 at the first cycle of the period) outputs phase P(k). P(0) = 0 and P(k+1) = P(k) + F(k) mod 2^32. F(0) is the lower frequency word. F(k+1) = min(F(k) + slope, upper word), with the sum taken without wrap. Every pulse starts again from k = 0.
- R4: Once a pulse is past its first sample, the frequency word never exceeds the upper word, including when the sum carries out of 32 bits.
- R5: `phase_o` is 0 in every cycle where `tx_gate_o` is low.
- R6: `done_o` is high for exactly one cycle, the cycle right after the last cycle of the final period. `tx_gate_o` is low in that cycle.
- R7: A pulse count of 0 produces no gate activity, and `done_o` is high in the cycle after the start edge.
- R8: A start is refused when `period` is 0 or `on_len > period`. In that case `err_o` is high for the one cycle after the start edge, and there is no gate and no `done_o`.
- R9: A write during a burst leaves that burst unchanged. The written value is used by the next accepted start.
- R10: `start_i` while a burst is running is ignored.
- R11: Write addresses are: 0 lower frequency word, 1 upper frequency word, 2 slope, 3 `on_len` (24 bits), 4 `period` (24 bits), 5 pulse count (16 bits). Addresses 6 and 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Shadow bank write strobe |
| cfg_addr_i | input | 3 | Shadow bank address |
| cfg_wdata_i | input | 32 | Write data, low bits used for narrower fields |
| start_i | input | 1 | Start command, single cycle |
| phase_o | output | 32 | Phase word per sample, zero outside the gate |
| tx_gate_o | output | 1 | Transmit gate |
| done_o | output | 1 | Burst complete strobe |
| err_o | output | 1 | Start refused strobe |

## Verification
The assertions assume that `start_i` and `cfg_we_i` are synchronous single-cycle or level inputs that are stable around the clock edge. They also assume that the working set changes only at an accepted start. This is why the frequency-cap property holds only while the burst runs from a loaded set.

The stimulus keeps `period` small, so full bursts, including back-to-back periods with `on_len == period`, complete within a few hundred cycles. One burst uses realistic slope and gate lengths. Mid-burst writes and starts are driven only on falling edges, so no change lands on the edge that samples them.

// File: rtl/lfm_chirp_pkg.sv
package lfm_chirp_pkg;
  parameter int unsigned PH_W  = 32;
  parameter int unsigned CNT_W = 24;
  parameter int unsigned NP_W  = 16;
  parameter int unsigned AD_W  = 3;

  typedef enum logic [AD_W-1:0] {
    ADR_F_LO   = 3'd0,
    ADR_F_HI   = 3'd1,
    ADR_SLOPE  = 3'd2,
    ADR_ON_LEN = 3'd3,
    ADR_PERIOD = 3'd4,
    ADR_NPULSE = 3'd5
  } cfg_addr_e;

  typedef struct packed {
    logic [PH_W-1:0]  f_lo;
    logic [PH_W-1:0]  f_hi;
    logic [PH_W-1:0]  slope;
    logic [CNT_W-1:0] on_len;
    logic [CNT_W-1:0] period;
    logic [NP_W-1:0]  n_pulse;
  } chirp_cfg_t;
endpackage

// File: rtl/lfm_cfg_bank.sv
module lfm_cfg_bank
  import lfm_chirp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AD_W-1:0]  addr_i,
  input  logic [PH_W-1:0]  wdata_i,
  input  logic             load_i,
  output chirp_cfg_t       shadow_o,
  output chirp_cfg_t       work_o
);
  chirp_cfg_t shadow_q, work_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
    end else if (we_i) begin
      case (addr_i)
        ADR_F_LO:   shadow_q.f_lo    <= wdata_i;
        ADR_F_HI:   shadow_q.f_hi    <= wdata_i;
        ADR_SLOPE:  shadow_q.slope   <= wdata_i;
        ADR_ON_LEN: shadow_q.on_len  <= wdata_i[CNT_W-1:0];
        ADR_PERIOD: shadow_q.period  <= wdata_i[CNT_W-1:0];
        ADR_NPULSE: shadow_q.n_pulse <= wdata_i[NP_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     work_q <= '0;
    else if (load_i) work_q <= shadow_q;
  end

  assign shadow_o = shadow_q;
  assign work_o   = work_q;
endmodule

// File: rtl/lfm_burst_seq.sv
module lfm_burst_seq
  import lfm_chirp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] sh_on_len_i,
  input  logic [CNT_W-1:0] sh_period_i,
  input  logic [NP_W-1:0]  sh_npulse_i,
  input  logic [CNT_W-1:0] wk_on_len_i,
  input  logic [CNT_W-1:0] wk_period_i,
  input  logic [NP_W-1:0]  wk_npulse_i,
  output logic             load_o,
  output logic             reload_o,
  output logic             active_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             gate_o,
  output logic             done_o,
  output logic             err_o
);
  logic             active_q, done_q, err_q;
  logic [CNT_W-1:0] cnt_q;
  logic [NP_W-1:0]  idx_q;
  logic             start_ok, bad_cfg, period_end, last_pulse;

  assign start_ok   = start_i && !active_q;
  assign bad_cfg    = (sh_period_i == '0) || (sh_on_len_i > sh_period_i);
  assign load_o     = start_ok && !bad_cfg;
  assign period_end = active_q && (cnt_q == wk_period_i - 1'b1);
  assign last_pulse = (idx_q == wk_npulse_i - 1'b1);
  assign reload_o   = load_o || period_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      cnt_q    <= '0;
      idx_q    <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (start_ok) begin
        if (bad_cfg) begin
          err_q <= 1'b1;
        end else if (sh_npulse_i == '0) begin
          done_q <= 1'b1;  // empty burst
        end else begin
          active_q <= 1'b1;
          cnt_q    <= '0;
          idx_q    <= '0;
        end
      end else if (active_q) begin
        if (period_end) begin
          cnt_q <= '0;
          if (last_pulse) begin
            active_q <= 1'b0;
            done_q   <= 1'b1;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign active_o = active_q;
  assign cnt_o    = cnt_q;
  assign gate_o   = active_q && (cnt_q < wk_on_len_i);
  assign done_o   = done_q;
  assign err_o    = err_q;
endmodule

// File: rtl/lfm_phase_acc.sv
module lfm_phase_acc
  import lfm_chirp_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            reload_i,
  input  logic [PH_W-1:0] f_lo_i,
  input  logic [PH_W-1:0] f_hi_i,
  input  logic [PH_W-1:0] slope_i,
  output logic [PH_W-1:0] freq_o,
  output logic [PH_W-1:0] phase_o
);
  logic [PH_W-1:0] freq_q, phase_q, freq_nxt;
  logic [PH_W:0]   freq_sum;

  // carry kept so a wrapped sum still clamps
  assign freq_sum = {1'b0, freq_q} + {1'b0, slope_i};
  assign freq_nxt = (freq_sum > {1'b0, f_hi_i}) ? f_hi_i : freq_sum[PH_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      freq_q  <= '0;
      phase_q <= '0;
    end else if (reload_i) begin
      freq_q  <= f_lo_i;
      phase_q <= '0;
    end else begin
      freq_q  <= freq_nxt;
      phase_q <= phase_q + freq_q;
    end
  end

  assign freq_o  = freq_q;
  assign phase_o = phase_q;
endmodule

// File: rtl/lfm_chirp_gen.sv
module lfm_chirp_gen
  import lfm_chirp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [AD_W-1:0]  cfg_addr_i,
  input  logic [PH_W-1:0]  cfg_wdata_i,
  input  logic             start_i,
  output logic [PH_W-1:0]  phase_o,
  output logic             tx_gate_o,
  output logic             done_o,
  output logic             err_o
);
  chirp_cfg_t       shadow_cfg, work_cfg;
  logic             load, reload, active, gate;
  logic [CNT_W-1:0] samp_cnt;
  logic [PH_W-1:0]  freq_q, phase_q, f_lo_sel;

  lfm_cfg_bank u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .addr_i   (cfg_addr_i),
    .wdata_i  (cfg_wdata_i),
    .load_i   (load),
    .shadow_o (shadow_cfg),
    .work_o   (work_cfg)
  );

  lfm_burst_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .sh_on_len_i (shadow_cfg.on_len),
    .sh_period_i (shadow_cfg.period),
    .sh_npulse_i (shadow_cfg.n_pulse),
    .wk_on_len_i (work_cfg.on_len),
    .wk_period_i (work_cfg.period),
    .wk_npulse_i (work_cfg.n_pulse),
    .load_o      (load),
    .reload_o    (reload),
    .active_o    (active),
    .cnt_o       (samp_cnt),
    .gate_o      (gate),
    .done_o      (done_o),
    .err_o       (err_o)
  );

  // working set is not loaded yet on the start edge
  assign f_lo_sel = load ? shadow_cfg.f_lo : work_cfg.f_lo;

  lfm_phase_acc u_acc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .reload_i (reload),
    .f_lo_i   (f_lo_sel),
    .f_hi_i   (work_cfg.f_hi),
    .slope_i  (work_cfg.slope),
    .freq_o   (freq_q),
    .phase_o  (phase_q)
  );

  assign tx_gate_o = gate;
  assign phase_o   = gate ? phase_q : '0;
endmodule

// File: rtl/lfm_chirp_gen_chk.sv
module lfm_chirp_gen_chk
  import lfm_chirp_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tx_gate_o,
  input logic [PH_W-1:0]  phase_o,
  input logic             done_o,
  input logic             err_o,
  input logic             active_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [PH_W-1:0]  freq_i,
  input chirp_cfg_t       work_i
);
  assert_cnt_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i |-> cnt_i < work_i.period);

  assert_phase_zero_at_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_gate_o) |-> phase_o == '0);

  assert_freq_cap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && cnt_i != '0) |-> freq_i <= work_i.f_hi);

  assert_done_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_no_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !tx_gate_o);

  assert_err_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);

  assert_err_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!tx_gate_o && !done_o));

  assert_work_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && $past(active_i)) |-> $stable(work_i));
endmodule

bind lfm_chirp_gen lfm_chirp_gen_chk chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tx_gate_o (tx_gate_o),
  .phase_o   (phase_o),
  .done_o    (done_o),
  .err_o     (err_o),
  .active_i  (active),
  .cnt_i     (samp_cnt),
  .freq_i    (freq_q),
  .work_i    (work_cfg)
);

// File: tb/lfm_chirp_gen_tb_top.sv
`timescale 1ns/1ps
module lfm_chirp_gen_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [2:0]  cfg_addr_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic        start_i = 1'b0;
  logic [31:0] phase_o;
  logic        tx_gate_o, done_o, err_o;

  always #4 clk_i = ~clk_i;  // 125 MHz

  lfm_chirp_gen dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we_i),
    .cfg_addr_i  (cfg_addr_i),
    .cfg_wdata_i (cfg_wdata_i),
    .start_i     (start_i),
    .phase_o     (phase_o),
    .tx_gate_o   (tx_gate_o),
    .done_o      (done_o),
    .err_o       (err_o)
  );

  typedef struct {
    bit          gate;
    bit          done;
    bit          err;
    logic [31:0] ph;
    string       req;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  longint unsigned sh [8];  // shadow model, R11 address map

  task automatic check_now(bit g, bit d, bit e, logic [31:0] p, string r);
    n_chk++;
    if (tx_gate_o !== g || done_o !== d || err_o !== e || phase_o !== p) begin
      n_bad++;
      $display("FAIL %s: gate=%0b done=%0b err=%0b phase=%h expected gate=%0b done=%0b err=%0b phase=%h",
               r, tx_gate_o, done_o, err_o, phase_o, g, d, e, p);
    end
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (q.size() != 0) begin
      exp_t e;
      e = q.pop_front();
      check_now(e.gate, e.done, e.err, e.ph, e.req);
    end
  end

  task automatic push(bit g, bit d, bit e, logic [31:0] p, string r);
    exp_t x;
    x.gate = g; x.done = d; x.err = e; x.ph = p; x.req = r;
    q.push_back(x);
  endtask

  task automatic wr(int a, longint unsigned d);
    @(negedge clk_i);
    cfg_we_i    = 1'b1;
    cfg_addr_i  = a[2:0];
    cfg_wdata_i = d[31:0];
    case (a)
      3, 4:    sh[a] = d & 64'hFF_FFFF;
      5:       sh[a] = d & 64'hFFFF;
      0, 1, 2: sh[a] = d & 64'hFFFF_FFFF;
      default: ;  // R11: ignored
    endcase
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic setup(longint unsigned f_lo, longint unsigned f_hi, longint unsigned slope,
                       longint unsigned on_len, longint unsigned period, longint unsigned np);
    wr(0, f_lo); wr(1, f_hi); wr(2, slope);
    wr(3, on_len); wr(4, period); wr(5, np);
  endtask

  // driver: expected items from the model
  task automatic build(string r);
    longint unsigned f_lo = sh[0], f_hi = sh[1], slope = sh[2];
    longint unsigned on_len = sh[3], period = sh[4], np = sh[5];
    if (period == 0 || on_len > period) begin
      push(0, 0, 1, 32'h0, "R8");
    end else if (np == 0) begin
      push(0, 1, 0, 32'h0, "R7");
    end else begin
      for (longint unsigned p = 0; p < np; p++) begin
        longint unsigned fr = f_lo;
        longint unsigned ph = 0;
        for (longint unsigned s = 0; s < period; s++) begin
          longint unsigned nf;
          if (s < on_len) push(1, 0, 0, ph[31:0], r);
          else            push(0, 0, 0, 32'h0, "R5");
          ph = (ph + fr) & 64'hFFFF_FFFF;
          nf = fr + slope;
          fr = (nf > f_hi) ? f_hi : nf;
        end
      end
      push(0, 1, 0, 32'h0, "R6");
    end
    push(0, 0, 0, 32'h0, "R6");
  endtask

  task automatic fire(string r);
    @(negedge clk_i);
    start_i = 1'b1;
    @(posedge clk_i);
    #1 start_i = 1'b0;
    build(r);
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) sh[i] = 0;
    repeat (3) @(negedge clk_i);
    check_now(0, 0, 0, 32'h0, "R1 in reset");
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check_now(0, 0, 0, 32'h0, "R1 after reset");

    // R2 R3: plain burst
    setup(1000, 100000, 300, 5, 9, 3);
    fire("R2");
    drain();

    // R4: clamp reached inside the gate
    setup(32'h1000_0000, 32'h1000_0800, 32'h300, 8, 10, 2);
    fire("R4");
    drain();

    // R4: sum carries out of 32 bits, on_len == period
    setup(32'hF000_0000, 32'hFFFF_FFFF, 32'h0800_0000, 6, 6, 2);
    fire("R4");
    drain();

    // R3: 40 MHz/us slope at 125 MS/s, 5 us and 20 us gates
    setup(32'h0100_0000, 32'h7000_0000, 10995116, 625, 650, 2);
    fire("R3");
    drain();
    setup(32'h0100_0000, 32'h7000_0000, 10995116, 2500, 2600, 1);
    fire("R3");
    drain();

    // R7: empty burst
    setup(500, 9000, 7, 3, 4, 0);
    fire("R7");
    drain();

    // R8: gate longer than period, then zero period
    setup(500, 9000, 7, 7, 6, 2);
    fire("R8");
    drain();
    wr(4, 0);
    wr(3, 0);
    fire("R8");
    drain();

    // R11: addresses 6 and 7 leave the bank unchanged
    setup(200, 50000, 40, 3, 5, 2);
    wr(6, 32'hFFFF_FFFF);
    wr(7, 32'hFFFF_FFFF);
    fire("R11");
    drain();

    // R9 R10: writes and start during a burst
    setup(2000, 80000, 123, 4, 7, 3);
    fire("R10");
    repeat (3) @(negedge clk_i);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    wr(3, 2);
    wr(0, 5555);
    @(negedge clk_i);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    drain();
    fire("R9");
    drain();

    repeat (2) @(negedge clk_i);
    summary();
    $finish;
  end
endmodule